// File: doc/BRIEF.md
# Gated Timer/Counter with Mode Select

This block is one timer/counter channel of the kind found in small 8-bit controllers. It advances a count held in a low and a high 8-bit register. The count source is either a peripheral clock-enable tick (timer use) or falling edges on an external count pin (counter use). Counting runs only while the run bit is set. When the gate bit is also set, counting further waits for an external gate pin to be high, so the channel can measure how long that pin stays high.

Two widths are offered. In the 13-bit mode, the five low bits of the low register act as a divide-by-32 prescaler that feeds the 8-bit high register, and the three upper low bits stay untouched. In the 16-bit mode, the low and high registers form one cascaded counter. A roll-over from all ones to all zeros in the active width sets a sticky overflow flag, and that flag drives the interrupt request. Software loads the count and the control bits through a simple write port, reads them back on dedicated outputs, and must stop the channel before it changes the mode.

Top module: `gtc_timer`

## Requirements
- R1: After reset the low count, high count, control read-back, overflow flag and interrupt request are all zero.
- R2: An increment can occur only when run is set and either gate is clear or the gate pin, after two synchronizing flip-flops, is high. With gate set and the synchronized pin low, the count holds.
- R3: In timer use (counter-select bit 0), each cycle with tick_en high and counting enabled adds one to the count.
- R4: In counter use (counter-select bit 1), the count pin passes two synchronizing flip-flops. The synchronized level is compared with the level held at the previous tick_en cycle, and one increment happens for each high-to-low change seen in a tick_en cycle. Rising edges and a steady pin add nothing.
- R5: In mode 00 (13-bit), increments add one to low bits [4:0] only. Low bits [7:5] never change by counting and are not used for carry. A carry out of bit 4 adds one to the high register.
- R6: In modes 01, 10 and 11 (16-bit), the low register counts through all 8 bits, and its carry from 0xFF adds one to the high register.
- R7: A roll-over of the whole active count from all ones to zero sets the overflow flag one clock later. The interrupt request output always equals the flag.
- R8: Once set, the flag stays set until irq_ack is high or a write to address 3 carries data bit 0 = 0. A write to address 3 with bit 0 = 1 sets the flag. An overflow in the same cycle wins over a clear.
- R9: Writes use address 0 for low, address 1 for high, address 2 for control and address 3 for the flag. A write to address 0 or 1 loads the data and cancels any increment in that cycle.
- R10: The control byte at address 2 uses bit 0 for run, bit 1 for gate, bit 2 for counter select and bits [4:3] for mode. ctrl_rd returns these five bits in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Peripheral clock-enable tick |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| gate_pin | input | 1 | External gate pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| cnt_lo | output | 8 | Low count register |
| cnt_hi | output | 8 | High count register |
| ctrl_rd | output | 5 | Control bits read-back |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler or carry state shows up on cnt_lo and cnt_hi at the very next enabled increment, because both registers are visible every cycle. It shows up on ovf_flag one cycle after a roll-over that goes missing or comes too early. A broken synchronizer or edge-detector state in counter use shows up as an extra or missing count about three cycles after a pin change. A broken gate path shows up as counting two cycles early or late after the gate pin moves. The bench compares every output in every cycle against a model built from the requirements, so any such divergence is seen in the cycle it first appears.

// File: rtl/gtc_timer.sv
module gtc_timer #(
  parameter int CW = 8,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          cnt_pin,
  input  logic          gate_pin,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          irq_ack,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [4:0]    ctrl_rd,
  output logic          ovf_flag,
  output logic          irq
);
  localparam logic [PW-1:0] PMAX = '1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] lo_q, hi_q;
  logic          run_q, gate_q, csel_q;
  logic [1:0]    mode_q;
  logic          flag_q;
  logic          g1_q, g2_q, p1_q, p2_q, prev_q;

  wire wide    = (mode_q != 2'b00);
  wire cnt_wr  = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);
  wire run_ok  = run_q && (!gate_q || g2_q);
  wire fall    = tick_en && prev_q && !p2_q;
  wire evt     = csel_q ? fall : tick_en;
  wire inc     = run_ok && evt && !cnt_wr;
  wire lo_cy   = wide ? (lo_q == CMAX) : (lo_q[PW-1:0] == PMAX);
  wire ovf     = inc && lo_cy && (hi_q == CMAX);
  wire flag_wr = wr_en && (wr_addr == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q <= 1'b0; g2_q <= 1'b0;
      p1_q <= 1'b0; p2_q <= 1'b0; prev_q <= 1'b0;
    end else begin
      g1_q <= gate_pin; g2_q <= g1_q;
      p1_q <= cnt_pin;  p2_q <= p1_q;
      if (tick_en) prev_q <= p2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; gate_q <= 1'b0; csel_q <= 1'b0; mode_q <= 2'b00;
    end else if (wr_en && wr_addr == 2'd2) begin
      run_q  <= wr_data[0];
      gate_q <= wr_data[1];
      csel_q <= wr_data[2];
      mode_q <= wr_data[4:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cnt_wr) begin
      if (wr_addr == 2'd0) lo_q <= wr_data;
      else                 hi_q <= wr_data;
    end else if (inc) begin
      if (wide) lo_q <= lo_q + 1'b1;
      else      lo_q <= {lo_q[CW-1:PW], lo_q[PW-1:0] + 1'b1};
      if (lo_cy) hi_q <= hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flag_q <= 1'b0;
    else if (ovf)                    flag_q <= 1'b1;
    else if (irq_ack)                flag_q <= 1'b0;
    else if (flag_wr)                flag_q <= wr_data[0];
  end

  assign cnt_lo   = lo_q;
  assign cnt_hi   = hi_q;
  assign ctrl_rd  = {mode_q, csel_q, gate_q, run_q};
  assign ovf_flag = flag_q;
  assign irq      = flag_q;

  p_wr_lo_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (cnt_lo == $past(wr_data)));

  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !g2_q && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !(wr_en && wr_addr == 2'd0)) |=> $stable(cnt_lo[CW-1:PW]));

  p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (ovf_flag && cnt_hi == '0));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !irq_ack && !flag_wr) |=> ovf_flag);

  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ovf_flag);
endmodule

// File: tb/gtc_timer_bench.sv
`timescale 1ns/1ps
module gtc_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 0, cnt_pin = 0, gate_pin = 0, wr_en = 0, irq_ack = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt_lo, cnt_hi;
  logic [4:0] ctrl_rd;
  logic ovf_flag, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  gtc_timer u_gtc_timer (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ack(irq_ack), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ctrl_rd(ctrl_rd),
    .ovf_flag(ovf_flag), .irq(irq));

  logic [7:0] m_lo, m_hi;
  logic [4:0] m_ctl;
  logic m_flag, m_g1, m_g2, m_p1, m_p2, m_prev;

  function automatic logic [16:0] step(logic [7:0] lo, logic [7:0] hi, logic [1:0] md);
    logic [7:0] nl, nh;
    logic o;
    if (md == 2'b00) begin
      nl = {lo[7:5], lo[4:0] + 5'd1};
      nh = (lo[4:0] == 5'h1f) ? hi + 8'd1 : hi;
      o  = (lo[4:0] == 5'h1f) && (hi == 8'hff);
    end else begin
      nl = lo + 8'd1;
      nh = (lo == 8'hff) ? hi + 8'd1 : hi;
      o  = (lo == 8'hff) && (hi == 8'hff);
    end
    return {o, nh, nl};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= 0; m_hi <= 0; m_ctl <= 0; m_flag <= 0;
      m_g1 <= 0; m_g2 <= 0; m_p1 <= 0; m_p2 <= 0; m_prev <= 0;
    end else begin
      logic en, ev, wc, o;
      logic [16:0] s;
      en = m_ctl[0] && (!m_ctl[1] || m_g2);
      ev = m_ctl[2] ? (tick_en && m_prev && !m_p2) : tick_en;
      wc = wr_en && wr_addr <= 2'd1;
      s  = step(m_lo, m_hi, m_ctl[4:3]);
      o  = en && ev && !wc && s[16];
      if (wc) begin
        if (wr_addr == 0) m_lo <= wr_data; else m_hi <= wr_data;
      end else if (en && ev) begin
        m_lo <= s[7:0]; m_hi <= s[15:8];
      end
      if (wr_en && wr_addr == 2) m_ctl <= wr_data[4:0];
      if (o) m_flag <= 1;
      else if (irq_ack) m_flag <= 0;
      else if (wr_en && wr_addr == 3) m_flag <= wr_data[0];
      m_g1 <= gate_pin; m_g2 <= m_g1;
      m_p1 <= cnt_pin; m_p2 <= m_p1;
      if (tick_en) m_prev <= m_p2;
    end
  end

  task automatic lit(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk(string tag);
    lit({tag, " lo"}, cnt_lo, m_lo);
    lit({tag, " hi"}, cnt_hi, m_hi);
    lit({tag, " ctrl R10"}, ctrl_rd, m_ctl);
    lit({tag, " flag R8"}, ovf_flag, m_flag);
    lit({tag, " irq R7"}, irq, m_flag);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(logic [4:0] ctl, logic [7:0] lo, logic [7:0] hi);
    wr(2, {3'b0, ctl & 5'b11110});
    wr(0, lo); wr(1, hi); wr(3, 0);
    wr(2, {3'b0, ctl});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    idle(2);
    lit("R1 lo", cnt_lo, 0); lit("R1 hi", cnt_hi, 0); lit("R1 ctrl", ctrl_rd, 0);
    lit("R1 flag", ovf_flag, 0); lit("R1 irq", irq, 0);
    rst_n = 1;
    idle(2);

    // R5: 13-bit roll-over, upper low bits kept
    setup(5'b00_0_0_1, 8'hff, 8'hff);
    tick_en = 1; @(negedge clk); tick_en = 0;
    lit("R5 lo upper kept", cnt_lo, 8'he0); lit("R5 hi wrap", cnt_hi, 0);
    @(negedge clk);
    lit("R7 flag set", ovf_flag, 1); lit("R7 irq", irq, 1);
    // R8: flag sticky, ack clears
    idle(3); lit("R8 sticky", ovf_flag, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    lit("R8 ack clears", ovf_flag, 0);
    wr(3, 1); lit("R8 write sets", ovf_flag, 1);
    wr(3, 0); lit("R8 write clears", ovf_flag, 0);
    // R5: upper bits set but prescaler not full -> no carry
    setup(5'b00_0_0_1, 8'he0, 8'h10);
    tick_en = 1; @(negedge clk); tick_en = 0;
    lit("R5 no carry lo", cnt_lo, 8'he1); lit("R5 no carry hi", cnt_hi, 8'h10);
    // R6: 16-bit carry, mode 10 acts as 16-bit
    setup(5'b10_0_0_1, 8'hff, 8'h12);
    tick_en = 1; @(negedge clk); tick_en = 0;
    lit("R6 lo wrap", cnt_lo, 0); lit("R6 hi carry", cnt_hi, 8'h13);
    @(negedge clk); lit("R6 no flag", ovf_flag, 0);
    // R9: write beats increment
    tick_en = 1; wr(0, 8'h55); tick_en = 0;
    lit("R9 write wins", cnt_lo, 8'h55);
    // R2: gate set, pin low -> hold
    setup(5'b01_0_1_1, 8'h20, 8'h00);
    tick_en = 1; idle(5);
    lit("R2 gated hold", cnt_lo, 8'h20);
    gate_pin = 1; idle(2); @(negedge clk); tick_en = 0;
    lit("R2 gate open counts", cnt_lo, 8'h21);
    gate_pin = 0; idle(3);
    // R4: counter use, falling edge only
    setup(5'b01_1_0_1, 8'h00, 8'h00);
    tick_en = 1; cnt_pin = 1; idle(5);
    lit("R4 high steady", cnt_lo, 0);
    cnt_pin = 0; idle(5);
    lit("R4 one fall", cnt_lo, 1);
    cnt_pin = 1; idle(5);
    lit("R4 rise ignored", cnt_lo, 1);
    tick_en = 0; cnt_pin = 0;
    idle(2);
    chk("R3 directed end");

    // random phases against model
    for (int ph = 0; ph < 16; ph++) begin
      logic [4:0] ctl;
      string tag;
      ctl = {2'($urandom), 1'($urandom), 1'($urandom), 1'b1};
      tag = (ctl[4:3] == 0) ? "R5 rnd" : (ctl[2] ? "R4 rnd" : "R6 rnd");
      setup(ctl, 8'($urandom), (ph[0]) ? 8'hff : 8'($urandom));
      for (int c = 0; c < 400; c++) begin
        tick_en  = ($urandom % 3) != 0;
        cnt_pin  = ($urandom % 4) == 0 ? ~cnt_pin : cnt_pin;
        gate_pin = ($urandom % 16) == 0 ? ~gate_pin : gate_pin;
        irq_ack  = ($urandom % 50) == 0;
        if ($urandom % 40 == 0) begin
          wr_en = 1; wr_addr = 2'($urandom % 2); wr_data = 8'($urandom);
        end else if ($urandom % 60 == 0) begin
          wr_en = 1; wr_addr = 3; wr_data = 8'($urandom);
        end else wr_en = 0;
        @(negedge clk);
        chk(ctl[2] ? tag : (ctl[1] ? "R2 rnd" : "R3 rnd"));
      end
      wr_en = 0; irq_ack = 0; tick_en = 0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule